// File: doc/BRIEF.md
# Lithium Cell Stack Protection Controller

This block is the digital core of a protector for a series stack of three or four lithium cells. It steps a cell-select output across the active cells, one cell per clock-enable tick. For the selected cell it reads four comparator flags: above the overcharge trip level, above the overcharge release level, below the undercharge trip level, and above the undercharge release level. A broken-tap flag is also read for the selected cell. From these flags it decides when to open the charge switch and the discharge switch. One pass over all active cells is a sample period. All decisions are made at the tick that closes a period.

A fault must persist for a set number of consecutive periods before the block acts on it. Overcharge opens the charge switch and holds it open until every cell has dropped below the release level. While in that band, the block closes the charge switch again whenever the sense-resistor flag shows discharge current, so the load current does not flow through a body diode. Undercharge opens both switches and puts the block to sleep. Only the wake input ends sleep. A wake runs a single trial period with both switches closed, and that period either restores normal operation or sends the block back to sleep. The charge-allow input gates the charge switch in every state.

Top module: `lcp_guard`

## Requirements
- R1: A synchronous reset puts the block in the normal state (state code 0) with cell_sel at 0. After reset, dsg_en is 1 and chg_en equals chg_allow.
- R2: Outside sleep, each cycle with tick high advances cell_sel by one. After the last active cell, cell_sel returns to 0. The last active cell is 3 when three_cell is 0 and 2 when three_cell is 1. With tick low, cell_sel holds.
- R3: From the normal state, the block enters the overcharge state (code 1) at the tick that closes the second of two consecutive periods in which some cell raised ov_set_hi. A period without that flag restarts the count. In this state, chg_en is 0 while dsg_sense is 0.
- R4: The overcharge state returns to normal at the end of the first period in which no cell reported ov_rel_hi, ov_set_hi or tap_open. A cell left between the two overcharge levels keeps the state unchanged.
- R5: In the overcharge state, chg_en follows chg_allow AND dsg_sense in the same cycle, and dsg_en stays 1.
- R6: From the normal or overcharge state, two consecutive periods in which some cell raised uv_set_lo put the block in sleep (code 2). In sleep, chg_en and dsg_en are both 0. This takes priority over an overcharge trip closing at the same tick.
- R7: In sleep, cell_sel stays at 0 and ticks have no effect. A clock edge with wake high moves the block to the wake-trial state (code 3), where dsg_en is 1 and chg_en equals chg_allow.
- R8: At the end of the wake-trial period, the block enters normal if every cell raised uv_rel_ok during that period. Otherwise it re-enters sleep.
- R9: With chg_allow low, chg_en is 0 in every state.
- R10: A cell whose tap_open is high counts as above both overcharge levels.
- R11: wake has no effect outside sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Clock enable; one cell is sampled per tick |
| three_cell | input | 1 | Cell-count strap: 0 for four cells, 1 for three |
| ov_set_hi | input | 1 | Selected cell is above the overcharge trip level |
| ov_rel_hi | input | 1 | Selected cell is above the overcharge release level |
| uv_set_lo | input | 1 | Selected cell is below the undercharge trip level |
| uv_rel_ok | input | 1 | Selected cell is above the undercharge release level |
| tap_open | input | 1 | Sense tap of the selected cell is broken |
| dsg_sense | input | 1 | Sense-resistor drop shows discharge current |
| chg_allow | input | 1 | Charge permitted by the pack |
| wake | input | 1 | Charger presence; ends sleep |
| cell_sel | output | 2 | Index of the cell being sampled |
| chg_en | output | 1 | Charge switch enable |
| dsg_en | output | 1 | Discharge switch enable |
| state | output | 2 | Controller state: 0 normal, 1 overcharge, 2 sleep, 3 wake trial |

## Verification
The two enables are combinational from the registered state and from chg_allow and dsg_sense, so they respond in the same cycle as those inputs. cell_sel and state change on the clock edge that samples the causing tick or wake, and a state change is due exactly at the edge of the tick that closes the deciding period. The bench drives inputs at the falling edge and derives the per-cell flags there from the cell_sel just registered. It compares all four outputs one nanosecond later against a behavioural model, and advances that model after each rising edge. Directed sequences are aligned to period boundaries, so each state check lands on the first cycle after the deciding tick.

// File: rtl/lcp_pkg.sv
package lcp_pkg;

    typedef enum logic [1:0] {
        ST_RUN = 2'd0,
        ST_OVC = 2'd1,
        ST_SLP = 2'd2,
        ST_WAK = 2'd3
    } lcp_state_e;

    // per-sample or per-period condition summary
    typedef struct packed {
        logic any_hi;    // some cell above overcharge trip
        logic any_band;  // some cell above overcharge release
        logic any_low;   // some cell below undercharge trip
        logic all_ok;    // every cell above undercharge release
    } lcp_agg_t;

    localparam lcp_agg_t AGG_IDLE = '{any_hi: 1'b0, any_band: 1'b0,
                                      any_low: 1'b0, all_ok: 1'b1};

endpackage

// File: rtl/lcp_scan.sv
module lcp_scan
    import lcp_pkg::*;
#(
    parameter int MAX_CELLS = 4,
    parameter int SEL_W     = $clog2(MAX_CELLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic             restart,
    input  logic             three_cell,
    input  lcp_agg_t         cur,
    output logic [SEL_W-1:0] cell_sel,
    output logic             period_end,
    output lcp_agg_t         agg
);
    localparam logic [SEL_W-1:0] LAST_FULL  = SEL_W'(MAX_CELLS - 1);
    localparam logic [SEL_W-1:0] LAST_SHORT = SEL_W'(MAX_CELLS - 2);

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        lcp_agg_t         acc;
    } scan_t;

    scan_t            s_d, s_q;
    logic [SEL_W-1:0] last_sel;

    always_comb begin
        last_sel     = three_cell ? LAST_SHORT : LAST_FULL;
        agg.any_hi   = s_q.acc.any_hi   | cur.any_hi;
        agg.any_band = s_q.acc.any_band | cur.any_band;
        agg.any_low  = s_q.acc.any_low  | cur.any_low;
        agg.all_ok   = s_q.acc.all_ok   & cur.all_ok;
        period_end   = tick && run && (s_q.sel >= last_sel);

        s_d = s_q;
        if (restart) begin
            s_d.sel = '0;
            s_d.acc = AGG_IDLE;
        end else if (tick && run) begin
            if (period_end) begin
                s_d.sel = '0;
                s_d.acc = AGG_IDLE;
            end else begin
                s_d.sel = s_q.sel + 1'b1;
                s_d.acc = agg;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.sel <= '0;
            s_q.acc <= AGG_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign cell_sel = s_q.sel;

endmodule

// File: rtl/lcp_delay.sv
module lcp_delay #(
    parameter int DELAY = 2,
    localparam int CW   = $clog2(DELAY + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    input  logic hit,
    output logic fire
);
    localparam logic [CW-1:0] LIMIT = CW'(DELAY);
    localparam logic [CW-1:0] PRE   = CW'(DELAY - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } dly_t;

    dly_t d_d, d_q;

    always_comb begin
        d_d  = d_q;
        fire = 1'b0;
        if (clear) begin
            d_d.cnt = '0;
        end else if (step) begin
            if (hit) begin
                fire = (d_q.cnt == PRE);
                if (d_q.cnt != LIMIT) d_d.cnt = d_q.cnt + 1'b1;
            end else begin
                d_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) d_q.cnt <= '0;
        else     d_q <= d_d;
    end

endmodule

// File: rtl/lcp_guard.sv
module lcp_guard
    import lcp_pkg::*;
#(
    parameter int MAX_CELLS     = 4,
    parameter int DELAY_PERIODS = 2,
    localparam int SEL_W        = $clog2(MAX_CELLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             three_cell,
    input  logic             ov_set_hi,
    input  logic             ov_rel_hi,
    input  logic             uv_set_lo,
    input  logic             uv_rel_ok,
    input  logic             tap_open,
    input  logic             dsg_sense,
    input  logic             chg_allow,
    input  logic             wake,
    output logic [SEL_W-1:0] cell_sel,
    output logic             chg_en,
    output logic             dsg_en,
    output logic [1:0]       state
);
    typedef struct packed {
        lcp_state_e st;
    } ctl_t;

    ctl_t     c_d, c_q;
    lcp_agg_t sample, agg;
    logic     period_end, run, restart;
    logic     uv_clear, ov_clear, uv_fire, ov_fire;

    // a broken tap reads as a cell above both overcharge levels
    assign sample = '{any_hi:   ov_set_hi | tap_open,
                      any_band: ov_set_hi | ov_rel_hi | tap_open,
                      any_low:  uv_set_lo,
                      all_ok:   uv_rel_ok};

    assign run      = (c_q.st != ST_SLP);
    assign restart  = (c_q.st == ST_SLP) && wake;
    assign uv_clear = (c_q.st == ST_SLP) || (c_q.st == ST_WAK);
    assign ov_clear = (c_q.st != ST_RUN);

    lcp_scan #(.MAX_CELLS(MAX_CELLS), .SEL_W(SEL_W)) u_scan (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .run       (run),
        .restart   (restart),
        .three_cell(three_cell),
        .cur       (sample),
        .cell_sel  (cell_sel),
        .period_end(period_end),
        .agg       (agg)
    );

    lcp_delay #(.DELAY(DELAY_PERIODS)) u_uv_dly (
        .clk  (clk),
        .rst  (rst),
        .clear(uv_clear),
        .step (period_end),
        .hit  (agg.any_low),
        .fire (uv_fire)
    );

    lcp_delay #(.DELAY(DELAY_PERIODS)) u_ov_dly (
        .clk  (clk),
        .rst  (rst),
        .clear(ov_clear),
        .step (period_end),
        .hit  (agg.any_hi),
        .fire (ov_fire)
    );

    always_comb begin
        c_d = c_q;
        unique case (c_q.st)
            ST_RUN: begin
                if (uv_fire)      c_d.st = ST_SLP;
                else if (ov_fire) c_d.st = ST_OVC;
            end
            ST_OVC: begin
                if (uv_fire)                         c_d.st = ST_SLP;
                else if (period_end && !agg.any_band) c_d.st = ST_RUN;
            end
            ST_SLP: begin
                if (wake) c_d.st = ST_WAK;
            end
            ST_WAK: begin
                if (period_end) c_d.st = agg.all_ok ? ST_RUN : ST_SLP;
            end
            default: c_d.st = ST_RUN;
        endcase

        dsg_en = (c_q.st != ST_SLP);
        unique case (c_q.st)
            ST_RUN, ST_WAK: chg_en = chg_allow;
            ST_OVC:         chg_en = chg_allow && dsg_sense;
            default:        chg_en = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) c_q.st <= ST_RUN;
        else     c_q <= c_d;
    end

    assign state = c_q.st;

endmodule

// File: rtl/lcp_guard_chk.sv
module lcp_guard_chk #(
    parameter int MAX_CELLS = 4,
    localparam int SEL_W    = $clog2(MAX_CELLS)
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             three_cell,
    input logic             wake,
    input logic [SEL_W-1:0] cell_sel,
    input logic [1:0]       state
);
    logic [SEL_W-1:0] last_c;
    assign last_c = three_cell ? SEL_W'(MAX_CELLS - 2) : SEL_W'(MAX_CELLS - 1);

    AST_SEL_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && state != 2'd2 && cell_sel < last_c) |=> cell_sel == $past(cell_sel) + 1'b1); // R2

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick && !(state == 2'd2 && wake)) |=> $stable(cell_sel)); // R2

    AST_SLEEP_STAY: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd2 && !wake) |=> (state == 2'd2 && cell_sel == '0)); // R7

    AST_WAKE_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd2 && wake) |=> (state == 2'd3 && cell_sel == '0)); // R7

    AST_OV_ONLY_FROM_RUN: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd1 && $past(state) != 2'd1) |-> $past(state) == 2'd0); // R3

    AST_SLEEP_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd2 && $past(state) != 2'd2) |-> $past(tick)); // R6

    AST_WAKE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd0 && !tick) |=> state == 2'd0); // R11

endmodule

bind lcp_guard lcp_guard_chk #(.MAX_CELLS(MAX_CELLS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .three_cell(three_cell),
    .wake      (wake),
    .cell_sel  (cell_sel),
    .state     (state)
);

// File: tb/tb_lcp_guard.sv
`timescale 1ns/1ps
module tb_lcp_guard;
    localparam int NC  = 4;
    localparam int DLY = 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, tick, three_cell, ov_set_hi, ov_rel_hi, uv_set_lo, uv_rel_ok;
    logic tap_open, dsg_sense, chg_allow, wake;
    logic [1:0] cell_sel, state;
    logic chg_en, dsg_en;

    lcp_guard dut (
        .clk(clk), .rst(rst), .tick(tick), .three_cell(three_cell),
        .ov_set_hi(ov_set_hi), .ov_rel_hi(ov_rel_hi), .uv_set_lo(uv_set_lo),
        .uv_rel_ok(uv_rel_ok), .tap_open(tap_open), .dsg_sense(dsg_sense),
        .chg_allow(chg_allow), .wake(wake), .cell_sel(cell_sel),
        .chg_en(chg_en), .dsg_en(dsg_en), .state(state)
    );

    // cell level: 0 below uv trip, 1 between uv levels, 2 healthy,
    // 3 between ov levels, 4 above ov trip
    int lvl [NC];
    bit opn [NC];
    int m_st, m_sel, m_uvc, m_ovc;
    bit a_hi, a_band, a_low, a_ok;
    int total = 0, bad = 0;
    bit done = 0;

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void drive_flags();
        int i;
        i = int'(cell_sel);
        ov_set_hi = (lvl[i] >= 4);
        ov_rel_hi = (lvl[i] >= 3);
        uv_set_lo = (lvl[i] == 0);
        uv_rel_ok = (lvl[i] >= 2);
        tap_open  = opn[i];
    endfunction

    function automatic void model_clear_acc();
        a_hi = 0; a_band = 0; a_low = 0; a_ok = 1;
    endfunction

    function automatic void model_clock();
        int last, nst;
        bit run, fin, g_hi, g_band, g_low, g_ok, uvf, ovf;
        if (rst) begin
            m_st = 0; m_sel = 0; m_uvc = 0; m_ovc = 0;
            model_clear_acc();
            return;
        end
        last   = three_cell ? NC - 2 : NC - 1;
        g_hi   = a_hi | ov_set_hi | tap_open;
        g_band = a_band | ov_set_hi | ov_rel_hi | tap_open;
        g_low  = a_low | uv_set_lo;
        g_ok   = a_ok & uv_rel_ok;
        run    = (m_st != 2);
        fin    = tick && run && (m_sel >= last);
        uvf = 0; ovf = 0;
        if (m_st == 2 || m_st == 3) m_uvc = 0;
        else if (fin) begin
            if (g_low) begin uvf = (m_uvc == DLY - 1); if (m_uvc < DLY) m_uvc++; end
            else m_uvc = 0;
        end
        if (m_st != 0) m_ovc = 0;
        else if (fin) begin
            if (g_hi) begin ovf = (m_ovc == DLY - 1); if (m_ovc < DLY) m_ovc++; end
            else m_ovc = 0;
        end
        nst = m_st;
        case (m_st)
            0: if (uvf) nst = 2; else if (ovf) nst = 1;
            1: if (uvf) nst = 2; else if (fin && !g_band) nst = 0;
            2: if (wake) nst = 3;
            default: if (fin) nst = g_ok ? 0 : 2;
        endcase
        if (m_st == 2 && wake) begin
            m_sel = 0; model_clear_acc();
        end else if (tick && run) begin
            if (fin) begin m_sel = 0; model_clear_acc(); end
            else begin
                m_sel++;
                a_hi = g_hi; a_band = g_band; a_low = g_low; a_ok = g_ok;
            end
        end
        m_st = nst;
    endfunction

    // one clock: flags follow cell_sel, compare, then advance the model
    task automatic cyc();
        int e_chg;
        drive_flags();
        #1;
        e_chg = (chg_allow && (m_st == 0 || m_st == 3 || (m_st == 1 && dsg_sense))) ? 1 : 0;
        check("R2 cell_sel", int'(cell_sel), m_sel);
        check("R4 state", int'(state), m_st);
        check("R9 chg_en", int'(chg_en), e_chg);
        check("R6 dsg_en", int'(dsg_en), (m_st != 2) ? 1 : 0);
        @(posedge clk);
        model_clock();
        @(negedge clk);
    endtask

    task automatic ticks(int n);
        tick = 1'b1;
        repeat (n) cyc();
        tick = 1'b0;
    endtask

    task automatic pulse_wake();
        wake = 1'b1; cyc(); wake = 1'b0;
    endtask

    function automatic void set_all(int v);
        for (int i = 0; i < NC; i++) begin lvl[i] = v; opn[i] = 0; end
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        set_all(2);
        m_st = 0; m_sel = 0; m_uvc = 0; m_ovc = 0; model_clear_acc();
        rst = 1; tick = 0; three_cell = 0; dsg_sense = 0; chg_allow = 1; wake = 0;
        drive_flags();
        @(negedge clk);
        repeat (3) cyc();
        rst = 0;
        check("R1 reset state", int'(state), 0);
        check("R1 reset cell_sel", int'(cell_sel), 0);
        check("R1 reset dsg_en", int'(dsg_en), 1);
        check("R1 reset chg_en", int'(chg_en), 1);

        pulse_wake();
        check("R11 wake in normal", int'(state), 0);

        ticks(2); repeat (3) cyc();
        check("R2 hold without tick", int'(cell_sel), 2);
        ticks(1);
        check("R2 four-cell last", int'(cell_sel), 3);
        ticks(1);
        check("R2 four-cell wrap", int'(cell_sel), 0);
        three_cell = 1;
        ticks(2);
        check("R2 three-cell last", int'(cell_sel), 2);
        ticks(1);
        check("R2 three-cell wrap", int'(cell_sel), 0);
        three_cell = 0;

        lvl[2] = 4; ticks(4);
        lvl[2] = 2; ticks(4);
        lvl[2] = 4; ticks(4);
        check("R3 count restarted", int'(state), 0);
        ticks(4);
        check("R3 overcharge entry", int'(state), 1);
        check("R3 charge off", int'(chg_en), 0);

        dsg_sense = 1; cyc();
        check("R5 smart discharge on", int'(chg_en), 1);
        check("R5 discharge kept", int'(dsg_en), 1);
        dsg_sense = 0; cyc();
        check("R5 smart discharge off", int'(chg_en), 0);
        chg_allow = 0; dsg_sense = 1; cyc();
        check("R9 allow low", int'(chg_en), 0);
        chg_allow = 1; dsg_sense = 0;

        lvl[2] = 3; ticks(4);
        check("R4 band holds", int'(state), 1);
        lvl[2] = 2; ticks(4);
        check("R4 release", int'(state), 0);

        opn[1] = 1; ticks(8);
        check("R10 open tap trips", int'(state), 1);
        opn[1] = 0; ticks(4);
        check("R10 open tap cleared", int'(state), 0);

        lvl[0] = 0; ticks(4);
        check("R6 one period only", int'(state), 0);
        ticks(4);
        check("R6 sleep entry", int'(state), 2);
        check("R6 discharge off", int'(dsg_en), 0);
        check("R6 charge off", int'(chg_en), 0);
        ticks(6);
        check("R7 sleep cell_sel", int'(cell_sel), 0);
        check("R7 sleep state", int'(state), 2);
        lvl[0] = 1; pulse_wake();
        check("R7 wake trial", int'(state), 3);
        check("R7 trial discharge on", int'(dsg_en), 1);
        check("R7 trial charge on", int'(chg_en), 1);
        ticks(4);
        check("R8 back to sleep", int'(state), 2);
        lvl[0] = 2; pulse_wake(); ticks(4);
        check("R8 recovered", int'(state), 0);

        lvl[0] = 0; lvl[1] = 4; ticks(8);
        check("R6 priority over overcharge", int'(state), 2);
        set_all(2); pulse_wake(); ticks(4);
        check("R8 recovered again", int'(state), 0);

        for (int n = 0; n < 6000; n++) begin
            tick = ($urandom % 2) == 0;
            wake = ($urandom % 8) == 0;
            if (($urandom % 8) == 0) dsg_sense = ~dsg_sense;
            if (($urandom % 40) == 0) chg_allow = ~chg_allow;
            if (($urandom % 500) == 0) three_cell = ~three_cell;
            if (($urandom % 24) == 0) begin
                int c, r;
                c = $urandom % NC;
                r = $urandom % 8;
                lvl[c] = (r < 2) ? r : (r < 6) ? 2 : r - 3;
                opn[c] = ($urandom % 16) == 0;
            end
            cyc();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule